// File: doc/BRIEF.md
# Dual Retriggerable One-Shot Timer

This block holds two independent one-shot pulse generators that run on the system clock. Each channel has three asynchronous control inputs: an active-low trigger, an active-high trigger and an active-low clear. A qualified edge on any of the three starts a pulse, and the pulse length is a count of clock cycles taken from that channel's length input. Each channel drives a true output that is high while the pulse runs, and a complementary output.

A valid trigger that arrives while a pulse is running reloads the full length. The pulse therefore ends one full period after the last trigger. Holding clear low ends a running pulse and blocks all firing. The inputs may come from any clock domain: each one passes through a two-flop synchronizer before edge detection.

Top module: `dual_oneshot_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, every channel returns to idle, with `q_o` low, `q_n_o` high and its count cleared.
- R2: A channel fires on a falling edge of its `trig_n_i` when its `trig_i` and `clr_n_i` are both high. Fix the edge at clock edge k, meaning the first edge that samples the new level. After edge k+2, `q_o` is high for exactly `len_i` cycles.
- R3: A channel fires on a rising edge of its `trig_i` when its `trig_n_i` is low and its `clr_n_i` is high. The latency and pulse length are the same as in R2.
- R4: A channel fires on a rising edge of its `clr_n_i` when its `trig_n_i` is low and its `trig_i` is high. The latency and pulse length are the same as in R2.
- R5: An edge on `trig_i` does not fire while `trig_n_i` is high. An edge on `trig_n_i` does not fire while `trig_i` is low. An idle channel with no qualified edge stays idle.
- R6: Once `clr_n_i` is low from clock edge k onward, `q_o` is low after edge k+2. No trigger fires while clear stays low.
- R7: A qualified trigger during a running pulse reloads the full length, so `q_o` falls `len_i` cycles after the last trigger takes effect.
- R8: A qualified trigger with `len_i` equal to zero produces no pulse.
- R9: `q_n_o` is the complement of `q_o` on every cycle.
- R10: The two channels share no state. The inputs of one channel never change the outputs of the other.
- R11: The pulse length is captured on the cycle the channel fires. A later change to `len_i` has no effect on the pulse already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_n_i | input | NCH | Active-low trigger per channel (fires on its falling edge) |
| trig_i | input | NCH | Active-high trigger per channel (fires on its rising edge) |
| clr_n_i | input | NCH | Active-low clear per channel (fires on its release) |
| len_i | input | NCH x CNT_W | Pulse length in clock cycles, one field per channel |
| q_o | output | NCH | True output per channel, high during the pulse |
| q_n_o | output | NCH | Complementary output per channel |

## Verification
If the count is wrong, the falling edge of `q_o` comes early or late. This shows at the port in the same cycle the count reaches zero, or when it should have. A stale edge-detect register appears as a spurious or missing pulse two clock edges after the input change. The reference model compares both outputs of both channels on every cycle, so an error shows within one cycle of the moment it reaches the port. Per-window pulse counts add a check on total pulse length after retriggers and clears.

// File: rtl/oneshot_pkg.sv
// Package: shared types for the dual one-shot timer.
// Assumes: the three control pins of a channel always travel together as one
// packed struct, in the bit order trig_n, trig, clr_n.
package oneshot_pkg;

    typedef struct packed {
        logic trig_n;
        logic trig;
        logic clr_n;
    } os_pins_t;

    // Level pattern that fires nothing: used as the synchronizer reset value.
    localparam os_pins_t PINS_IDLE = '{trig_n: 1'b1, trig: 1'b0, clr_n: 1'b1};

    // Which trigger path fired; the order sets the priority when several fire at once.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FALL = 2'd1,
        SRC_RISE = 2'd2,
        SRC_CLR  = 2'd3
    } os_src_e;

endpackage

// File: rtl/os_sync.sv
// Module: os_sync
// Brings the three control pins of one channel into the clock domain through
// STAGES flops. It also keeps the previous synchronized value for edge detection.
// Assumes: STAGES >= 2. Reset loads the idle pattern, so the release of reset
// never looks like an edge.
module os_sync
    import oneshot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  os_pins_t raw_i,
    output os_pins_t cur_o,
    output os_pins_t prv_o
);

    localparam int LAST = STAGES - 1;

    os_pins_t pipe_q [STAGES];
    os_pins_t prv_q;

    // Shift the raw pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= PINS_IDLE;
            end
        end else begin
            pipe_q[0] <= raw_i;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    // Keep the last synchronized value one cycle longer for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prv_q <= PINS_IDLE;
        end else begin
            prv_q <= pipe_q[LAST];
        end
    end

    assign cur_o = pipe_q[LAST];
    assign prv_o = prv_q;

endmodule

// File: rtl/os_edge_qual.sv
// Module: os_edge_qual
// Finds the edges on the three synchronized pins and gates each edge with the
// level of the other two. The result is one fire pulse per cycle.
// Assumes: cur/prv come from the same synchronizer, one cycle apart.
module os_edge_qual
    import oneshot_pkg::*;
(
    input  os_pins_t cur_i,
    input  os_pins_t prv_i,
    output logic     fire_o
);

    logic    fall_tn, rise_t, rise_c;
    logic    gate_tn, gate_t, gate_c;
    os_src_e src;

    // Raw edge detection on each synchronized pin.
    always_comb begin
        fall_tn = prv_i.trig_n & ~cur_i.trig_n;
        rise_t  = ~prv_i.trig  &  cur_i.trig;
        rise_c  = ~prv_i.clr_n &  cur_i.clr_n;
    end

    // Level qualification: each edge needs the other two pins in the enabling state.
    always_comb begin
        gate_tn = cur_i.trig    & cur_i.clr_n;
        gate_t  = ~cur_i.trig_n & cur_i.clr_n;
        gate_c  = ~cur_i.trig_n & cur_i.trig;
    end

    // Priority pick of the firing path.
    always_comb begin
        if (fall_tn && gate_tn) begin
            src = SRC_FALL;
        end else if (rise_t && gate_t) begin
            src = SRC_RISE;
        end else if (rise_c && gate_c) begin
            src = SRC_CLR;
        end else begin
            src = SRC_NONE;
        end
    end

    assign fire_o = (src != SRC_NONE);

endmodule

// File: rtl/os_counter.sv
// Module: os_counter
// Down-counter that times one pulse. A fire loads the length and a low clear
// empties the counter. The pulse is active while the count is non-zero.
// Assumes: clr_n_i is already synchronized. fire_i is only asserted while
// clr_n_i is high, but clear wins regardless.
module os_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n_i,
    input  logic             fire_i,
    input  logic [CNT_W-1:0] len_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             active_o
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Clear, reload on fire, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= ZERO;
        end else if (!clr_n_i) begin
            cnt_q <= ZERO;
        end else if (fire_i) begin
            cnt_q <= len_i;
        end else if (cnt_q != ZERO) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_o    = cnt_q;
    assign active_o = (cnt_q != ZERO);

endmodule

// File: rtl/os_channel.sv
// Module: os_channel
// One complete one-shot: synchronizer, edge qualifier, counter and output pair.
// Assumes: the control pins may be asynchronous to clk. len_i is sampled only
// on the cycle the channel fires.
module os_channel
    import oneshot_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_n_i,
    input  logic             trig_i,
    input  logic             clr_n_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             q_o,
    output logic             q_n_o,
    output logic             fire_o,
    output logic [CNT_W-1:0] cnt_o
);

    os_pins_t raw, cur, prv;
    logic     fire, active;

    // Bundle the three pins for the synchronizer.
    always_comb begin
        raw.trig_n = trig_n_i;
        raw.trig   = trig_i;
        raw.clr_n  = clr_n_i;
    end

    os_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw),
        .cur_o (cur),
        .prv_o (prv)
    );

    os_edge_qual u_qual (
        .cur_i  (cur),
        .prv_i  (prv),
        .fire_o (fire)
    );

    os_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_n_i  (cur.clr_n),
        .fire_i   (fire),
        .len_i    (len_i),
        .cnt_o    (cnt_o),
        .active_o (active)
    );

    assign q_o    = active;
    assign q_n_o  = ~active;
    assign fire_o = fire;

endmodule

// File: rtl/dual_oneshot_timer.sv
// Module: dual_oneshot_timer
// Top level: NCH independent retriggerable one-shot channels, each with its
// own pins, clear and length field.
// Assumes: a synchronous active-low reset. Each channel's length is in clock
// cycles, and zero means no pulse.
module dual_oneshot_timer #(
    parameter int NCH   = 2,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NCH-1:0]            trig_n_i,
    input  logic [NCH-1:0]            trig_i,
    input  logic [NCH-1:0]            clr_n_i,
    input  logic [NCH-1:0][CNT_W-1:0] len_i,
    output logic [NCH-1:0]            q_o,
    output logic [NCH-1:0]            q_n_o
);

    localparam int SYNC_STAGES = 2;

    logic [NCH-1:0]            ch_fire;
    logic [NCH-1:0][CNT_W-1:0] ch_cnt;

    // One channel instance per index; the channels share nothing but the clock and reset.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        os_channel #(
            .CNT_W       (CNT_W),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig_n_i (trig_n_i[c]),
            .trig_i   (trig_i[c]),
            .clr_n_i  (clr_n_i[c]),
            .len_i    (len_i[c]),
            .q_o      (q_o[c]),
            .q_n_o    (q_n_o[c]),
            .fire_o   (ch_fire[c]),
            .cnt_o    (ch_cnt[c])
        );
    end

endmodule

// File: rtl/os_checker.sv
// Module: os_checker
// Property checks for dual_oneshot_timer, attached by bind. They observe the
// per-channel fire strobe, the counter and the ports.
module os_checker #(
    parameter int NCH   = 2,
    parameter int CNT_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NCH-1:0]            clr_n_i,
    input logic [NCH-1:0][CNT_W-1:0] len_i,
    input logic [NCH-1:0]            q_o,
    input logic [NCH-1:0]            fire,
    input logic [NCH-1:0][CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R6
        clr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_n_i[c] && !$past(clr_n_i[c]) && !$past(clr_n_i[c], 2)) |=> !q_o[c]);

        // R8
        zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!q_o[c] && len_i[c] == '0) |=> !q_o[c]);

        // R7
        load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire[c] |=> cnt[c] == $past(len_i[c]));

        // R5
        idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!fire[c] && cnt[c] == '0) |=> cnt[c] == '0);

        // R2
        countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[c] != '0 && !fire[c] && clr_n_i[c] && $past(clr_n_i[c]) && $past(clr_n_i[c], 2))
            |=> cnt[c] == $past(cnt[c]) - ONE);
    end

endmodule

bind dual_oneshot_timer os_checker #(.NCH(NCH), .CNT_W(CNT_W)) u_os_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n_i (clr_n_i),
    .len_i   (len_i),
    .q_o     (q_o),
    .fire    (ch_fire),
    .cnt     (ch_cnt)
);

// File: tb/tb_dual_oneshot_timer.sv
module tb_dual_oneshot_timer;

    localparam int NCH   = 2;
    localparam int CNT_W = 16;

    logic                      clk = 1'b0;
    logic                      rst_n;
    logic [NCH-1:0]            tn, t, cn;
    logic [NCH-1:0][CNT_W-1:0] len;
    logic [NCH-1:0]            q_o, q_n_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    string cur_req = "R1";

    // Reference model state: raw pin history {trig_n,trig,clr_n}, newest at index 0.
    logic [2:0] hist [NCH][4];
    int m_cnt [NCH];
    int hi [NCH];

    always #5 clk = ~clk;

    dual_oneshot_timer #(.NCH(NCH), .CNT_W(CNT_W)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_n_i (tn),
        .trig_i   (t),
        .clr_n_i  (cn),
        .len_i    (len),
        .q_o      (q_o),
        .q_n_o    (q_n_o)
    );

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            failures++;
            $display("FAIL %s watchdog actual=%0d expected<=50000", cur_req, cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Advance the model over the edge just passed, then compare both outputs.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_cnt[c] = 0;
                for (int k = 0; k < 4; k++) hist[c][k] = 3'b101;
            end else begin
                logic [2:0] cur, prv;
                logic fire;
                for (int k = 3; k > 0; k--) hist[c][k] = hist[c][k-1];
                hist[c][0] = {tn[c], t[c], cn[c]};
                cur = hist[c][2];
                prv = hist[c][3];
                fire = (prv[2] && !cur[2] && cur[1] && cur[0])
                    || (!prv[1] && cur[1] && !cur[2] && cur[0])
                    || (!prv[0] && cur[0] && !cur[2] && cur[1]);
                if (!cur[0]) m_cnt[c] = 0;
                else if (fire) m_cnt[c] = int'(len[c]);
                else if (m_cnt[c] > 0) m_cnt[c] = m_cnt[c] - 1;
            end
            if (q_o[c]) hi[c]++;
            chk(cur_req, int'(q_o[c]), int'(m_cnt[c] != 0));
            // R9: complementary output
            chk("R9", int'(q_n_o[c]), int'(m_cnt[c] == 0));
        end
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic clear_hi();
        for (int c = 0; c < NCH; c++) hi[c] = 0;
    endtask

    task automatic go_idle();
        tn = '1; t = '0; cn = '1;
        steps(4);
    endtask

    initial begin
        rst_n = 1'b0;
        tn = '1; t = '0; cn = '1;
        len = '0;
        for (int c = 0; c < NCH; c++) begin
            m_cnt[c] = 0;
            hi[c] = 0;
            for (int k = 0; k < 4; k++) hist[c][k] = 3'b101;
        end
        // R1: reset state
        cur_req = "R1";
        steps(3);
        chk("R1", int'(q_o), 0);
        chk("R1", int'(q_n_o), 3);
        rst_n = 1'b1;
        steps(3);

        // R2: falling edge of trig_n with trig high
        cur_req = "R2";
        len[0] = 16'd5;
        t[0] = 1'b1; steps(3);
        clear_hi();
        tn[0] = 1'b0; steps(2);
        chk("R2", int'(q_o[0]), 0);
        step();
        chk("R2", int'(q_o[0]), 1);
        steps(10);
        chk("R2", hi[0], 5);
        go_idle();

        // R3: rising edge of trig with trig_n low
        cur_req = "R3";
        len[1] = 16'd3;
        tn[1] = 1'b0; steps(3);
        clear_hi();
        t[1] = 1'b1; steps(10);
        chk("R3", hi[1], 3);
        go_idle();

        // R4: release of clear with trig_n low and trig high
        cur_req = "R4";
        len[0] = 16'd6;
        cn[0] = 1'b0; steps(3);
        tn[0] = 1'b0; t[0] = 1'b1; steps(4);
        clear_hi();
        cn[0] = 1'b1; steps(12);
        chk("R4", hi[0], 6);
        go_idle();

        // R5: edges blocked by the other trigger's level
        cur_req = "R5";
        len[0] = 16'd4;
        clear_hi();
        t[0] = 1'b1; steps(3);
        t[0] = 1'b0; steps(3);
        tn[0] = 1'b0; steps(3);
        tn[0] = 1'b1; steps(3);
        tn[0] = 1'b0; steps(4);
        chk("R5", hi[0], 0);
        go_idle();

        // R6: clear ends a pulse and blocks triggers
        cur_req = "R6";
        len[0] = 16'd20;
        t[0] = 1'b1; steps(3);
        tn[0] = 1'b0; steps(6);
        cn[0] = 1'b0; steps(3);
        chk("R6", int'(q_o[0]), 0);
        clear_hi();
        tn[0] = 1'b1; steps(2);
        tn[0] = 1'b0; steps(5);
        chk("R6", hi[0], 0);
        go_idle();

        // R7: retrigger restarts the full period
        cur_req = "R7";
        len[0] = 16'd6;
        t[0] = 1'b1; steps(3);
        clear_hi();
        tn[0] = 1'b0; steps(2);
        tn[0] = 1'b1; steps(2);
        tn[0] = 1'b0; steps(16);
        chk("R7", hi[0], 10);
        go_idle();

        // R8: zero length gives no pulse
        cur_req = "R8";
        len[1] = 16'd0;
        t[1] = 1'b1; steps(3);
        clear_hi();
        tn[1] = 1'b0; steps(8);
        chk("R8", hi[1], 0);
        go_idle();

        // R10: channels run independently
        cur_req = "R10";
        len[0] = 16'd4; len[1] = 16'd7;
        t = '1; steps(3);
        clear_hi();
        tn = '0; steps(12);
        chk("R10", hi[0], 4);
        chk("R10", hi[1], 7);
        go_idle();
        len[0] = 16'd5;
        cn[1] = 1'b0; t[1] = 1'b1; t[0] = 1'b1; steps(3);
        clear_hi();
        tn[0] = 1'b0; steps(10);
        chk("R10", hi[0], 5);
        chk("R10", hi[1], 0);
        go_idle();

        // R11: length captured at fire time
        cur_req = "R11";
        len[1] = 16'd5;
        t[1] = 1'b1; steps(3);
        clear_hi();
        tn[1] = 1'b0; steps(4);
        len[1] = 16'd50; steps(10);
        chk("R11", hi[1], 5);
        go_idle();

        summary();
        $finish;
    end

endmodule